// File: doc/BRIEF.md
# I2C Bus Controller Interrupt Register Bank

This block holds the software-visible registers of a group of I2C bus controllers, one register window per bus, plus a shared read-only global word. Each bus window carries function control, two timing words, an interrupt enable word, an interrupt status word, a command word, a pool control word and a byte buffer. Every register keeps only its own writable bits. The protocol engine and the DMA engine sit outside; they reach the bank only through status-set pulses and a few hardware-owned fields.

Status bits are raised by one-cycle set pulses from the command sequencer. A raise merges the new bits into the status word and then masks the whole word with the enable register. If anything survives, the bus interrupt line goes high. Software clears status by writing ones. A write that leaves the status word at zero drops the bus line. The global word shows one summary bit per bus and follows the interrupt lines.

The register port is a single-cycle request with a byte address. Read data returns one cycle after a read request. The global word sits at address 0x000. Bus N occupies the 64-byte window at 0x040*(N+1).

Top module: `i2c_irq_regbank`

## Requirements
- R1: After reset every register reads zero, every bus interrupt line is low and the global word reads zero.
- R2: Read data and rd_valid_o appear exactly one cycle after a read request; writes produce no read response.
- R3: Function control (word offset 0x00) keeps only the bits in 0x0071C3FF. A write that has bit 1 (slave enable) set is dropped entirely, and the old value stays.
- R4: Timing word 1 (0x04) keeps bits under mask 0x0FFFFF0F. Timing word 2 (0x08) keeps bits 2:0. Interrupt enable (0x0C) keeps bits 14:0. Command (0x14) keeps all 32 bits.
- R5: A set pulse on a bus computes status = (status | set) & enable. If the result is non-zero, the bus interrupt line and that bus's global bit (bit N for bus N) go high. Set bit order: 0 transmit ack, 1 transmit nak, 2 receive done, 3 arbitration lost, 4 normal stop, 5 abnormal stop, 6 clock-low timeout; bits 7 to 14 are generic.
- R6: A write to interrupt status (0x10) clears each of bits 14:0 written as one; bits 31:15 of the write are ignored, and status bits 31:15 read zero.
- R7: The bus interrupt line and its global bit fall only on a status write that leaves status zero (including a write of zero). A partial clear keeps them high. A raise that masks status down to zero leaves the line unchanged.
- R8: Byte buffer (0x20): a write updates only bits 7:0 (transmit byte). A hardware receive-byte strobe loads bits 15:8.
- R9: Pool control (0x1C): a write updates only bits 23:0. Bits 31:24 are loaded only by the hardware receive-count strobe.
- R10: The slave address word (0x18), bus offsets 0x24 and above, misaligned addresses, global offsets other than 0x000 and windows beyond the last bus all read 0xFFFFFFFF. Writes to them, and to the global word, change nothing.
- R11: When a status write and a set pulse hit the same bus in the same cycle, the clear is applied first, then the set and the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| evt_set_i | input | NUM_BUS*15 | Status set pulses, 15 bits per bus |
| rx_byte_vld_i | input | NUM_BUS | Receive byte strobe per bus |
| rx_byte_i | input | NUM_BUS*8 | Received byte per bus |
| rx_cnt_vld_i | input | NUM_BUS | Receive count strobe per bus |
| rx_cnt_i | input | NUM_BUS*8 | Receive count per bus |
| irq_o | output | NUM_BUS | Interrupt line per bus |

## Verification
A status clear written by software and a status raise from the sequencer can land on the same bus in the same cycle. The bench drives both in one cycle, in two cases. In the first, the clear removes the very bit being raised; the raise must win, so status stays non-zero and the line stays high. In the second, the clear removes an old bit while a new bit is raised; only the new bit must remain. Both results are judged from the status read and the interrupt line.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int DW    = 32;
  localparam int STS_W = 15;

  typedef enum logic [3:0] {
    W_FCTL  = 4'd0,
    W_TIM1  = 4'd1,
    W_TIM2  = 4'd2,
    W_IEN   = 4'd3,
    W_STS   = 4'd4,
    W_CMD   = 4'd5,
    W_SADDR = 4'd6,
    W_POOL  = 4'd7,
    W_BUF   = 4'd8
  } word_e;

  localparam logic [DW-1:0] FCTL_MASK = 32'h0071_C3FF;
  localparam logic [DW-1:0] TIM1_MASK = 32'h0FFF_FF0F;
  localparam int            SLV_EN    = 1;
  localparam logic [DW-1:0] RD_MISS   = '1;
endpackage

// File: rtl/i2c_rb_decode.sv
module i2c_rb_decode
  import i2c_rb_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int ADDR_W  = 12
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              glob_sel_o,
  output logic [NUM_BUS-1:0] bus_sel_o,
  output logic [3:0]        word_o
);
  localparam int WIN_LSB  = 6;
  localparam int REGION_W = ADDR_W - WIN_LSB;

  logic [REGION_W-1:0] region;
  logic                aligned;

  assign region  = addr_i[ADDR_W-1:WIN_LSB];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign word_o  = addr_i[5:2];

  assign glob_sel_o = req_i && aligned && (region == '0) && (word_o == 4'd0);

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_sel
    assign bus_sel_o[g] = req_i && aligned && (region == REGION_W'(g + 1));
  end
endmodule

// File: rtl/i2c_rb_irq.sv
module i2c_rb_irq
  import i2c_rb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] en_i,
  input  logic             wr_i,
  input  logic [STS_W-1:0] clr_i,
  output logic [STS_W-1:0] sts_o,
  output logic             irq_o
);
  logic [STS_W-1:0] sts_q, sts_n, after_clr;
  logic             irq_q, irq_n;
  logic             raise;

  assign raise = |set_i;

  always_comb begin
    after_clr = wr_i ? (sts_q & ~clr_i) : sts_q;
    sts_n     = raise ? ((after_clr | set_i) & en_i) : after_clr;
    if (raise && (sts_n != '0))    irq_n = 1'b1;
    else if (wr_i && (sts_n == '0)) irq_n = 1'b0;
    else                            irq_n = irq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_n;
      irq_q <= irq_n;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = irq_q;

  // R5: after a raise no disabled bit survives
  a_r5_masked_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise |=> ((sts_o & ~$past(en_i)) == '0));
  // R5: line only rises on a raise
  a_r5_rise_on_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(raise));
  // R6: a pure clear write removes the written bits
  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !raise) |=> ((sts_o & $past(clr_i)) == '0));
  // R7: a write leaving zero status drops the line
  a_r7_drop_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (sts_o != '0 || !irq_o));
  // R7: the line never falls without a status write
  a_r7_fall_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_i));
endmodule

// File: rtl/i2c_rb_bus_regs.sv
module i2c_rb_bus_regs
  import i2c_rb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [3:0]       word_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rx_byte_vld_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_cnt_vld_i,
  input  logic [7:0]       rx_cnt_i,
  input  logic [STS_W-1:0] sts_i,
  output logic [STS_W-1:0] ien_o,
  output logic             sts_wr_o,
  output logic [STS_W-1:0] sts_clr_o,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0]    fctl_q, tim1_q, cmd_q;
  logic [2:0]       tim2_q;
  logic [STS_W-1:0] ien_q;
  logic [23:0]      pool_lo_q;
  logic [7:0]       pool_cnt_q, txb_q, rxb_q;
  logic             wr;

  assign wr = sel_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fctl_q    <= '0;
      tim1_q    <= '0;
      tim2_q    <= '0;
      ien_q     <= '0;
      cmd_q     <= '0;
      pool_lo_q <= '0;
      txb_q     <= '0;
    end else if (wr) begin
      case (word_i)
        W_FCTL: if (!wdata_i[SLV_EN]) fctl_q <= wdata_i & FCTL_MASK;
        W_TIM1: tim1_q    <= wdata_i & TIM1_MASK;
        W_TIM2: tim2_q    <= wdata_i[2:0];
        W_IEN:  ien_q     <= wdata_i[STS_W-1:0];
        W_CMD:  cmd_q     <= wdata_i;
        W_POOL: pool_lo_q <= wdata_i[23:0];
        W_BUF:  txb_q     <= wdata_i[7:0];
        default: ;
      endcase
    end
  end

  // hardware-owned fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pool_cnt_q <= '0;
      rxb_q      <= '0;
    end else begin
      if (rx_cnt_vld_i)  pool_cnt_q <= rx_cnt_i;
      if (rx_byte_vld_i) rxb_q      <= rx_byte_i;
    end
  end

  assign ien_o     = ien_q;
  assign sts_wr_o  = wr && (word_i == W_STS);
  assign sts_clr_o = wdata_i[STS_W-1:0];

  always_comb begin
    case (word_i)
      W_FCTL:  rdata_o = fctl_q;
      W_TIM1:  rdata_o = tim1_q;
      W_TIM2:  rdata_o = {29'd0, tim2_q};
      W_IEN:   rdata_o = {{(DW-STS_W){1'b0}}, ien_q};
      W_STS:   rdata_o = {{(DW-STS_W){1'b0}}, sts_i};
      W_CMD:   rdata_o = cmd_q;
      W_POOL:  rdata_o = {pool_cnt_q, pool_lo_q};
      W_BUF:   rdata_o = {16'd0, rxb_q, txb_q};
      default: rdata_o = RD_MISS;
    endcase
  end

  // R3: slave-enable write is dropped
  a_r3_slave_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word_i == W_FCTL && wdata_i[SLV_EN]) |=> $stable(fctl_q));
  // R9: receive count moves only with its strobe
  a_r9_cnt_hw_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_cnt_vld_i |=> $stable(pool_cnt_q));
  // R8: receive byte moves only with its strobe
  a_r8_rxb_hw_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_byte_vld_i |=> $stable(rxb_q));
endmodule

// File: rtl/i2c_irq_regbank.sv
module i2c_irq_regbank
  import i2c_rb_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int ADDR_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic                     rd_valid_o,
  output logic [31:0]              rdata_o,
  input  logic [NUM_BUS*STS_W-1:0] evt_set_i,
  input  logic [NUM_BUS-1:0]       rx_byte_vld_i,
  input  logic [NUM_BUS*8-1:0]     rx_byte_i,
  input  logic [NUM_BUS-1:0]       rx_cnt_vld_i,
  input  logic [NUM_BUS*8-1:0]     rx_cnt_i,
  output logic [NUM_BUS-1:0]       irq_o
);
  localparam int GLOB_PAD = DW - NUM_BUS;

  logic               glob_sel;
  logic [NUM_BUS-1:0] bus_sel;
  logic [3:0]         word;
  logic [DW-1:0]      bus_rd [NUM_BUS];
  logic [DW-1:0]      rd_mux;
  logic [NUM_BUS-1:0] irq;

  i2c_rb_decode #(.NUM_BUS(NUM_BUS), .ADDR_W(ADDR_W)) u_dec (
    .req_i     (req_i),
    .addr_i    (addr_i),
    .glob_sel_o(glob_sel),
    .bus_sel_o (bus_sel),
    .word_o    (word)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic [STS_W-1:0] ien, sts, clr;
    logic             sts_wr;

    i2c_rb_bus_regs u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sel_i        (bus_sel[b]),
      .we_i         (we_i),
      .word_i       (word),
      .wdata_i      (wdata_i),
      .rx_byte_vld_i(rx_byte_vld_i[b]),
      .rx_byte_i    (rx_byte_i[b*8 +: 8]),
      .rx_cnt_vld_i (rx_cnt_vld_i[b]),
      .rx_cnt_i     (rx_cnt_i[b*8 +: 8]),
      .sts_i        (sts),
      .ien_o        (ien),
      .sts_wr_o     (sts_wr),
      .sts_clr_o    (clr),
      .rdata_o      (bus_rd[b])
    );

    i2c_rb_irq u_irq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt_set_i[b*STS_W +: STS_W]),
      .en_i  (ien),
      .wr_i  (sts_wr),
      .clr_i (clr),
      .sts_o (sts),
      .irq_o (irq[b])
    );
  end

  always_comb begin
    rd_mux = RD_MISS;
    if (glob_sel) rd_mux = {{GLOB_PAD{1'b0}}, irq};
    for (int b = 0; b < NUM_BUS; b++) begin
      if (bus_sel[b]) rd_mux = bus_rd[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      rd_valid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
    end
  end

  assign irq_o = irq;

  // R2: one-cycle read response, none for writes
  a_r2_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rd_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(req_i && !we_i));
endmodule

// File: tb/i2c_irq_regbank_tb.sv
module i2c_irq_regbank_tb;
  localparam int NB = 4;
  localparam int AW = 12;
  localparam int SW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rd_valid;
  logic [31:0] rdata;
  logic [NB*SW-1:0] evt = '0;
  logic [NB-1:0] rxb_vld = '0, rxc_vld = '0;
  logic [NB*8-1:0] rxb = '0, rxc = '0;
  logic [NB-1:0] irq;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] q_exp[$];
  int          q_cyc[$];
  string       q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_irq_regbank #(.NUM_BUS(NB), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rd_valid_o(rd_valid), .rdata_o(rdata),
    .evt_set_i(evt), .rx_byte_vld_i(rxb_vld), .rx_byte_i(rxb),
    .rx_cnt_vld_i(rxc_vld), .rx_cnt_i(rxc), .irq_o(irq));

  function automatic logic [AW-1:0] ba(int bus, int off);
    return AW'((bus + 1) * 64 + off);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    q_exp.push_back(exp); q_cyc.push_back(cyc); q_tag.push_back(tag);
    @(negedge clk); req = 0;
  endtask

  task automatic raise(int bus, logic [SW-1:0] s);
    @(negedge clk); evt[bus*SW +: SW] = s;
    @(negedge clk); evt = '0;
  endtask

  task automatic clr_and_raise(int bus, logic [31:0] c, logic [SW-1:0] s);
    @(negedge clk); req = 1; we = 1; addr = ba(bus, 'h10); wdata = c;
    evt[bus*SW +: SW] = s;
    @(negedge clk); req = 0; we = 0; evt = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (q_exp.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 unexpected read response actual=%h expected=none", rdata);
      end else begin
        check({q_tag[0], " data"}, rdata, q_exp[0]);
        check("R2 latency", 32'(cyc - q_cyc[0]), 32'd1);
        void'(q_exp.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end else if (q_exp.size() != 0 && cyc > q_cyc[0] + 1) begin
      checks++; failures++;
      $display("FAIL R2 missing read response actual=none expected=%h", q_exp[0]);
      void'(q_exp.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    rd(12'h000, 32'h0, "R1 global");
    rd(ba(0, 'h00), 32'h0, "R1 fctl");
    rd(ba(1, 'h1C), 32'h0, "R1 pool");
    // R3 function control
    wr(ba(0, 'h00), 32'hFFFF_FFFD);
    rd(ba(0, 'h00), 32'h0071_C3FD, "R3 fctl mask");
    wr(ba(0, 'h00), 32'h0000_0003);
    rd(ba(0, 'h00), 32'h0071_C3FD, "R3 slave reject");
    // R4 masks
    wr(ba(0, 'h04), 32'hFFFF_FFFF);
    wr(ba(0, 'h08), 32'hFFFF_FFFF);
    wr(ba(0, 'h0C), 32'hFFFF_FFFF);
    wr(ba(0, 'h14), 32'hDEAD_BEEF);
    rd(ba(0, 'h04), 32'h0FFF_FF0F, "R4 tim1");
    rd(ba(0, 'h08), 32'h0000_0007, "R4 tim2");
    rd(ba(0, 'h0C), 32'h0000_7FFF, "R4 ien");
    rd(ba(0, 'h14), 32'hDEAD_BEEF, "R4 cmd");
    // R5 raise with enable
    raise(0, 15'h0005);
    check("R5 irq0 high", 32'(irq[0]), 32'd1);
    rd(ba(0, 'h10), 32'h5, "R5 sts");
    rd(12'h000, 32'h1, "R5 global");
    // R5 masked raise on bus1
    raise(1, 15'h0002);
    check("R5 masked irq1", 32'(irq[1]), 32'd0);
    rd(ba(1, 'h10), 32'h0, "R5 masked sts");
    // R6/R7 partial then full clear
    wr(ba(0, 'h10), 32'hFFFF_8001);
    rd(ba(0, 'h10), 32'h4, "R6 w1c upper ignored");
    check("R7 partial keeps irq0", 32'(irq[0]), 32'd1);
    wr(ba(0, 'h10), 32'h0000_0004);
    check("R7 irq0 low", 32'(irq[0]), 32'd0);
    rd(12'h000, 32'h0, "R7 global cleared");
    // R7 masked-to-zero raise keeps line; zero write drops it
    wr(ba(2, 'h0C), 32'h3);
    raise(2, 15'h0001);
    check("R5 irq2 high", 32'(irq[2]), 32'd1);
    wr(ba(2, 'h0C), 32'h0);
    raise(2, 15'h0002);
    check("R7 masked raise keeps irq2", 32'(irq[2]), 32'd1);
    rd(ba(2, 'h10), 32'h0, "R7 sts masked to zero");
    wr(ba(2, 'h10), 32'h0);
    check("R7 zero write drops irq2", 32'(irq[2]), 32'd0);
    // R11 same-cycle clear and raise
    wr(ba(3, 'h0C), 32'h7FFF);
    raise(3, 15'h0010);
    clr_and_raise(3, 32'h10, 15'h0010);
    rd(ba(3, 'h10), 32'h10, "R11 raise wins over clear");
    check("R11 irq3 high", 32'(irq[3]), 32'd1);
    clr_and_raise(3, 32'h10, 15'h0020);
    rd(ba(3, 'h10), 32'h20, "R11 old cleared new kept");
    check("R11 irq3 still high", 32'(irq[3]), 32'd1);
    // R8 byte buffer
    wr(ba(0, 'h20), 32'hFFFF_FFAB);
    rd(ba(0, 'h20), 32'h0000_00AB, "R8 tx only");
    @(negedge clk); rxb_vld[0] = 1; rxb[7:0] = 8'h5C;
    @(negedge clk); rxb_vld = '0;
    rd(ba(0, 'h20), 32'h0000_5CAB, "R8 rx byte");
    wr(ba(0, 'h20), 32'h0000_0011);
    rd(ba(0, 'h20), 32'h0000_5C11, "R8 write keeps rx");
    // R9 pool control
    wr(ba(1, 'h1C), 32'hFFFF_FFFF);
    rd(ba(1, 'h1C), 32'h00FF_FFFF, "R9 low only");
    @(negedge clk); rxc_vld[1] = 1; rxc[15:8] = 8'h12;
    @(negedge clk); rxc_vld = '0;
    rd(ba(1, 'h1C), 32'h12FF_FFFF, "R9 hw count");
    wr(ba(1, 'h1C), 32'h0);
    rd(ba(1, 'h1C), 32'h1200_0000, "R9 write keeps count");
    // R10 unmapped and read-only
    wr(ba(0, 'h18), 32'h0000_0055);
    rd(ba(0, 'h18), 32'hFFFF_FFFF, "R10 slave addr");
    rd(ba(0, 'h24), 32'hFFFF_FFFF, "R10 beyond buf");
    rd(12'h004, 32'hFFFF_FFFF, "R10 global offset");
    rd(AW'((NB + 1) * 64), 32'hFFFF_FFFF, "R10 no such bus");
    rd(ba(0, 'h01), 32'hFFFF_FFFF, "R10 misaligned");
    wr(12'h000, 32'hFFFF_FFFF);
    wr(ba(0, 'h25), 32'hFFFF_FFFF);
    rd(ba(0, 'h04), 32'h0FFF_FF0F, "R10 misaligned write ignored");
    rd(12'h000, 32'h8, "R10 global read-only");
    // R2 no response for writes
    repeat (4) @(negedge clk);
    check("R2 queue drained", 32'(q_exp.size()), 32'd0);
    finish_run();
  end
endmodule